// File: doc/BRIEF.md
# Split-Queue Integer Reservation Scheduler

This block is the issue stage for three integer pipelines. Each pipeline has its own reservation queue of ten macro-op slots. A dispatched macro-op carries an identifier and four source-operand tags. The first two tags feed its arithmetic/logic half and the last two feed its address-generation half. Each half waits on its own two sources only. The two halves of one macro-op leave the queue independently, in whichever order their operands become ready.

A source counts as ready in one of two ways. Its register-file valid bit may be set at dispatch. Otherwise its tag must match one of the result-bus tags broadcast in a cycle. A bus match can issue the waiting half in that same cycle, so a consumer never waits for a register write and read-back. A match that has already passed is remembered in the entry.

Each pipeline has two issue ports, one per half. Every cycle each port selects the oldest eligible half in its queue. When the last half of a macro-op issues, the block reports that macro-op's identifier on a completion lane in the same cycle, and the slot becomes free at the next clock edge. A flush input empties every queue at once.

Top module: `int_sched`

## Requirements
- R1: There are three queues, one per pipeline. Each queue accepts exactly 10 outstanding macro-ops, and queues fill and drain independently of each other.
- R2: Dispatch tag fields 0 and 1 are the sources of the arithmetic/logic half, and fields 2 and 3 are the sources of the address half. Each half waits only on its own two sources.
- R3: A half is eligible when each of its sources either had its register-file bit set at dispatch or has matched a valid result-bus tag. A match in the current cycle makes the half eligible in that same cycle. A half dispatched in cycle t can issue at the earliest in cycle t+1.
- R4: The two halves of one macro-op may issue in either order.
- R5: In one cycle, one pipeline can issue the arithmetic half of one macro-op and the address half of another.
- R6: A macro-op's identifier is reported in the cycle its last half issues. Completion lane 2q reports completion caused by the arithmetic port of queue q, including the case where both halves issue together. Lane 2q+1 reports completion caused by the address port alone.
- R7: Each issue port picks the eligible half whose macro-op was dispatched earliest, whatever slot it occupies.
- R8: The ready output of a queue is low while the queue holds 10 macro-ops, and a dispatch presented while ready is low is dropped. A slot freed by a completion makes ready high again in the following cycle.
- R9: Source tags are compared with the result buses in the dispatch cycle itself, so a broadcast in that cycle is not lost.
- R10: While flush is high, no half issues, every ready output is low and any dispatch is dropped. After the flush, every queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty all queues; blocks issue and dispatch this cycle |
| dsp_vld | input | NQ | Dispatch request, one per queue |
| dsp_rdy | output | NQ | Queue can take a dispatch this cycle |
| dsp_id | input | NQ*ID_W | Macro-op identifier per queue |
| dsp_tag | input | NQ*4*TAG_W | Four source tags per queue (0,1 arithmetic; 2,3 address) |
| dsp_rf | input | NQ*4 | Register-file valid bit per source tag |
| bus_vld | input | NBUS | Result-bus valid per bus |
| bus_tag | input | NBUS*TAG_W | Result-bus destination tags |
| alu_iss_vld | output | NQ | Arithmetic half issued, per pipeline |
| alu_iss_id | output | NQ*ID_W | Identifier of the issued arithmetic half |
| agu_iss_vld | output | NQ | Address half issued, per pipeline |
| agu_iss_id | output | NQ*ID_W | Identifier of the issued address half |
| cmp_vld | output | 2*NQ | Completion lanes, two per queue |
| cmp_id | output | 2*NQ*ID_W | Identifier of the completed macro-op per lane |

## Verification
The property checks rely on two assumptions about the environment. First, a dispatch counts only in a cycle where both request and ready are high. Second, the identifiers of macro-ops outstanding in one queue are all different, which the distinct-lane check needs. The occupancy model inside the checker counts accepted dispatches and reported completions, and it assumes every macro-op eventually completes or is flushed. The stimulus gives every macro-op in a queue its own identifier. It raises result-bus tags only for operands it has chosen to leave waiting. It presents a dispatch to a full or flushing queue only to show that the request is dropped.

// File: rtl/int_sched_pkg.sv
package int_sched_pkg;
    localparam int TAG_W = 6;
    localparam int ID_W  = 6;
    localparam int NSRC  = 2;
    localparam int NOPS  = 2 * NSRC;

    typedef logic [TAG_W-1:0] tag_t;
    typedef logic [ID_W-1:0]  mop_id_t;

    typedef struct packed {
        logic                  done;
        logic [NSRC-1:0]       rdy;
        tag_t [NSRC-1:0]       src;
    } half_t;

    typedef struct packed {
        logic    vld;
        mop_id_t id;
        half_t   alu;
        half_t   agu;
    } entry_t;
endpackage

// File: rtl/sched_tag_match.sv
module sched_tag_match
    import int_sched_pkg::*;
#(
    parameter int NBUS = 3
) (
    input  tag_t                    tag_i,
    input  logic [NBUS-1:0]         bus_vld_i,
    input  logic [NBUS*TAG_W-1:0]   bus_tag_i,
    output logic                    hit_o
);
    always_comb begin
        hit_o = 1'b0;
        for (int b = 0; b < NBUS; b++) begin
            if (bus_vld_i[b] && (bus_tag_i[b*TAG_W +: TAG_W] == tag_i)) begin
                hit_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sched_age_pick.sv
module sched_age_pick #(
    parameter int N = 10
) (
    input  logic [N-1:0]   elig_i,
    input  logic [N*N-1:0] older_i,   // bit j*N+i set: slot j is older than slot i
    output logic [N-1:0]   gnt_o
);
    always_comb begin
        for (int i = 0; i < N; i++) begin
            logic blk;
            blk = 1'b0;
            for (int j = 0; j < N; j++) begin
                if (elig_i[j] && older_i[j*N + i]) begin
                    blk = 1'b1;
                end
            end
            gnt_o[i] = elig_i[i] && !blk;
        end
    end
endmodule

// File: rtl/sched_queue.sv
module sched_queue
    import int_sched_pkg::*;
#(
    parameter int DEPTH = 10,
    parameter int NBUS  = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush_i,
    input  logic                   dsp_vld_i,
    output logic                   dsp_rdy_o,
    input  mop_id_t                dsp_id_i,
    input  logic [NOPS*TAG_W-1:0]  dsp_tag_i,
    input  logic [NOPS-1:0]        dsp_rf_i,
    input  logic [NBUS-1:0]        bus_vld_i,
    input  logic [NBUS*TAG_W-1:0]  bus_tag_i,
    output logic                   alu_vld_o,
    output mop_id_t                alu_id_o,
    output logic                   agu_vld_o,
    output mop_id_t                agu_id_o,
    output logic [1:0]             cmp_vld_o,
    output logic [2*ID_W-1:0]      cmp_id_o
);
    localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        entry_t [DEPTH-1:0]       ent;
        logic [DEPTH*DEPTH-1:0]   older;
    } qstate_t;

    qstate_t st_q, st_d;

    logic [DEPTH-1:0][NSRC-1:0] hit_alu, hit_agu;
    logic [NOPS-1:0]            hit_dsp;
    logic [DEPTH-1:0]           vld_vec, elig_alu, elig_agu, gnt_alu, gnt_agu;

    // wakeup comparators for waiting entries and for the incoming dispatch
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
        for (genvar gs = 0; gs < NSRC; gs++) begin : g_src
            sched_tag_match #(.NBUS(NBUS)) u_alu_match (
                .tag_i     (st_q.ent[gi].alu.src[gs]),
                .bus_vld_i (bus_vld_i),
                .bus_tag_i (bus_tag_i),
                .hit_o     (hit_alu[gi][gs])
            );
            sched_tag_match #(.NBUS(NBUS)) u_agu_match (
                .tag_i     (st_q.ent[gi].agu.src[gs]),
                .bus_vld_i (bus_vld_i),
                .bus_tag_i (bus_tag_i),
                .hit_o     (hit_agu[gi][gs])
            );
        end
    end

    for (genvar gk = 0; gk < NOPS; gk++) begin : g_dsp
        sched_tag_match #(.NBUS(NBUS)) u_dsp_match (
            .tag_i     (dsp_tag_i[gk*TAG_W +: TAG_W]),
            .bus_vld_i (bus_vld_i),
            .bus_tag_i (bus_tag_i),
            .hit_o     (hit_dsp[gk])
        );
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            vld_vec[i]  = st_q.ent[i].vld;
            elig_alu[i] = st_q.ent[i].vld && !st_q.ent[i].alu.done && !flush_i
                          && (&(st_q.ent[i].alu.rdy | hit_alu[i]));
            elig_agu[i] = st_q.ent[i].vld && !st_q.ent[i].agu.done && !flush_i
                          && (&(st_q.ent[i].agu.rdy | hit_agu[i]));
        end
        dsp_rdy_o = !(&vld_vec) && !flush_i;
    end

    sched_age_pick #(.N(DEPTH)) u_pick_alu (
        .elig_i  (elig_alu),
        .older_i (st_q.older),
        .gnt_o   (gnt_alu)
    );

    sched_age_pick #(.N(DEPTH)) u_pick_agu (
        .elig_i  (elig_agu),
        .older_i (st_q.older),
        .gnt_o   (gnt_agu)
    );

    always_comb begin
        logic [SLOT_W-1:0] slot;
        entry_t            nw;

        st_d      = st_q;
        alu_id_o  = '0;
        agu_id_o  = '0;
        cmp_vld_o = '0;
        cmp_id_o  = '0;
        alu_vld_o = |gnt_alu;
        agu_vld_o = |gnt_agu;

        for (int i = 0; i < DEPTH; i++) begin
            if (gnt_alu[i]) alu_id_o = st_q.ent[i].id;
            if (gnt_agu[i]) agu_id_o = st_q.ent[i].id;

            if (gnt_alu[i] && (st_q.ent[i].agu.done || gnt_agu[i])) begin
                cmp_vld_o[0]           = 1'b1;
                cmp_id_o[0 +: ID_W]    = st_q.ent[i].id;
            end
            if (gnt_agu[i] && st_q.ent[i].alu.done) begin
                cmp_vld_o[1]           = 1'b1;
                cmp_id_o[ID_W +: ID_W] = st_q.ent[i].id;
            end

            st_d.ent[i].alu.rdy = st_q.ent[i].alu.rdy | hit_alu[i];
            st_d.ent[i].agu.rdy = st_q.ent[i].agu.rdy | hit_agu[i];
            if (gnt_alu[i]) st_d.ent[i].alu.done = 1'b1;
            if (gnt_agu[i]) st_d.ent[i].agu.done = 1'b1;
            if (st_d.ent[i].alu.done && st_d.ent[i].agu.done) begin
                st_d.ent[i].vld = 1'b0;
            end
        end

        // lowest free slot
        slot = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!st_q.ent[i].vld) slot = SLOT_W'(i);
        end

        nw.vld      = 1'b1;
        nw.id       = dsp_id_i;
        nw.alu.done = 1'b0;
        nw.agu.done = 1'b0;
        for (int s = 0; s < NSRC; s++) begin
            nw.alu.src[s] = dsp_tag_i[s*TAG_W +: TAG_W];
            nw.alu.rdy[s] = dsp_rf_i[s] | hit_dsp[s];
            nw.agu.src[s] = dsp_tag_i[(s+NSRC)*TAG_W +: TAG_W];
            nw.agu.rdy[s] = dsp_rf_i[s+NSRC] | hit_dsp[s+NSRC];
        end

        if (dsp_vld_i && dsp_rdy_o) begin
            st_d.ent[slot] = nw;
            for (int j = 0; j < DEPTH; j++) begin
                st_d.older[j*DEPTH + int'(slot)] = st_q.ent[j].vld;
            end
            for (int j = 0; j < DEPTH; j++) begin
                st_d.older[int'(slot)*DEPTH + j] = 1'b0;
            end
        end

        if (flush_i) begin
            for (int i = 0; i < DEPTH; i++) st_d.ent[i].vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/int_sched.sv
module int_sched
    import int_sched_pkg::*;
#(
    parameter int NQ    = 3,
    parameter int DEPTH = 10,
    parameter int NBUS  = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush,
    input  logic [NQ-1:0]             dsp_vld,
    output logic [NQ-1:0]             dsp_rdy,
    input  logic [NQ*ID_W-1:0]        dsp_id,
    input  logic [NQ*NOPS*TAG_W-1:0]  dsp_tag,
    input  logic [NQ*NOPS-1:0]        dsp_rf,
    input  logic [NBUS-1:0]           bus_vld,
    input  logic [NBUS*TAG_W-1:0]     bus_tag,
    output logic [NQ-1:0]             alu_iss_vld,
    output logic [NQ*ID_W-1:0]        alu_iss_id,
    output logic [NQ-1:0]             agu_iss_vld,
    output logic [NQ*ID_W-1:0]        agu_iss_id,
    output logic [2*NQ-1:0]           cmp_vld,
    output logic [2*NQ*ID_W-1:0]      cmp_id
);
    for (genvar gq = 0; gq < NQ; gq++) begin : g_q
        sched_queue #(.DEPTH(DEPTH), .NBUS(NBUS)) u_queue (
            .clk       (clk),
            .rst_n     (rst_n),
            .flush_i   (flush),
            .dsp_vld_i (dsp_vld[gq]),
            .dsp_rdy_o (dsp_rdy[gq]),
            .dsp_id_i  (dsp_id[gq*ID_W +: ID_W]),
            .dsp_tag_i (dsp_tag[gq*NOPS*TAG_W +: NOPS*TAG_W]),
            .dsp_rf_i  (dsp_rf[gq*NOPS +: NOPS]),
            .bus_vld_i (bus_vld),
            .bus_tag_i (bus_tag),
            .alu_vld_o (alu_iss_vld[gq]),
            .alu_id_o  (alu_iss_id[gq*ID_W +: ID_W]),
            .agu_vld_o (agu_iss_vld[gq]),
            .agu_id_o  (agu_iss_id[gq*ID_W +: ID_W]),
            .cmp_vld_o (cmp_vld[2*gq +: 2]),
            .cmp_id_o  (cmp_id[2*gq*ID_W +: 2*ID_W])
        );
    end
endmodule

// File: rtl/int_sched_chk.sv
module int_sched_chk
    import int_sched_pkg::*;
#(
    parameter int NQ    = 3,
    parameter int DEPTH = 10
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  flush,
    input logic [NQ-1:0]         dsp_vld,
    input logic [NQ-1:0]         dsp_rdy,
    input logic [NQ-1:0]         alu_iss_vld,
    input logic [NQ*ID_W-1:0]    alu_iss_id,
    input logic [NQ-1:0]         agu_iss_vld,
    input logic [NQ*ID_W-1:0]    agu_iss_id,
    input logic [2*NQ-1:0]       cmp_vld,
    input logic [2*NQ*ID_W-1:0]  cmp_id
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    for (genvar gq = 0; gq < NQ; gq++) begin : g_chk
        logic [CNT_W-1:0] occ_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     occ_q <= '0;
            else if (flush) occ_q <= '0;
            else            occ_q <= occ_q + CNT_W'(dsp_vld[gq] && dsp_rdy[gq])
                                     - CNT_W'(cmp_vld[2*gq]) - CNT_W'(cmp_vld[2*gq+1]);
        end

        // R1
        occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            occ_q <= CNT_W'(DEPTH));

        // R8
        occ_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !flush |-> (dsp_rdy[gq] == (occ_q != CNT_W'(DEPTH))));

        // R10
        flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            flush |-> (!alu_iss_vld[gq] && !agu_iss_vld[gq] && !dsp_rdy[gq]));

        // R6
        cmp_alu_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cmp_vld[2*gq] |-> (alu_iss_vld[gq] &&
                cmp_id[2*gq*ID_W +: ID_W] == alu_iss_id[gq*ID_W +: ID_W]));

        // R6
        cmp_agu_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cmp_vld[2*gq+1] |-> (agu_iss_vld[gq] &&
                cmp_id[(2*gq+1)*ID_W +: ID_W] == agu_iss_id[gq*ID_W +: ID_W]));

        // R5
        lane_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cmp_vld[2*gq] && cmp_vld[2*gq+1]) |->
                (cmp_id[2*gq*ID_W +: ID_W] != cmp_id[(2*gq+1)*ID_W +: ID_W]));
    end
endmodule

bind int_sched int_sched_chk #(.NQ(NQ), .DEPTH(DEPTH)) u_int_sched_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .dsp_vld     (dsp_vld),
    .dsp_rdy     (dsp_rdy),
    .alu_iss_vld (alu_iss_vld),
    .alu_iss_id  (alu_iss_id),
    .agu_iss_vld (agu_iss_vld),
    .agu_iss_id  (agu_iss_id),
    .cmp_vld     (cmp_vld),
    .cmp_id      (cmp_id)
);

// File: tb/int_sched_bench.sv
`timescale 1ns/1ps
module int_sched_bench;
    import int_sched_pkg::*;

    localparam int NQ    = 3;
    localparam int DEPTH = 10;
    localparam int NBUS  = 3;

    logic                      clk = 1'b0;
    logic                      rst_n;
    logic                      flush;
    logic [NQ-1:0]             dsp_vld;
    logic [NQ-1:0]             dsp_rdy;
    logic [NQ*ID_W-1:0]        dsp_id;
    logic [NQ*NOPS*TAG_W-1:0]  dsp_tag;
    logic [NQ*NOPS-1:0]        dsp_rf;
    logic [NBUS-1:0]           bus_vld;
    logic [NBUS*TAG_W-1:0]     bus_tag;
    logic [NQ-1:0]             alu_iss_vld, agu_iss_vld;
    logic [NQ*ID_W-1:0]        alu_iss_id, agu_iss_id;
    logic [2*NQ-1:0]           cmp_vld;
    logic [2*NQ*ID_W-1:0]      cmp_id;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    int_sched #(.NQ(NQ), .DEPTH(DEPTH), .NBUS(NBUS)) u_int_sched (
        .clk, .rst_n, .flush, .dsp_vld, .dsp_rdy, .dsp_id, .dsp_tag, .dsp_rf,
        .bus_vld, .bus_tag, .alu_iss_vld, .alu_iss_id, .agu_iss_vld, .agu_iss_id,
        .cmp_vld, .cmp_id
    );

    task automatic expect_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_inputs();
        flush   = 1'b0;
        dsp_vld = '0;
        dsp_id  = '0;
        dsp_tag = '0;
        dsp_rf  = '0;
        bus_vld = '0;
        bus_tag = '0;
    endtask

    task automatic tick();
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic put(input int q, input int id, input int t0, input int t1,
                       input int t2, input int t3, input logic [3:0] rf);
        dsp_vld[q]                              = 1'b1;
        dsp_id[q*ID_W +: ID_W]                  = ID_W'(id);
        dsp_tag[(q*NOPS+0)*TAG_W +: TAG_W]      = TAG_W'(t0);
        dsp_tag[(q*NOPS+1)*TAG_W +: TAG_W]      = TAG_W'(t1);
        dsp_tag[(q*NOPS+2)*TAG_W +: TAG_W]      = TAG_W'(t2);
        dsp_tag[(q*NOPS+3)*TAG_W +: TAG_W]      = TAG_W'(t3);
        dsp_rf[q*NOPS +: NOPS]                  = rf;
    endtask

    task automatic pulse(input int b, input int tag);
        bus_vld[b]                  = 1'b1;
        bus_tag[b*TAG_W +: TAG_W]   = TAG_W'(tag);
    endtask

    // samples 1 ns after the inputs of this cycle were driven
    task automatic look(input string req, input int q,
                        input int av, input int aid, input int gv, input int gid,
                        input int c0v, input int c0id, input int c1v, input int c1id);
        #1;
        expect_eq(req, $sformatf("q%0d alu_vld", q), int'(alu_iss_vld[q]), av);
        if (av != 0) expect_eq(req, $sformatf("q%0d alu_id", q), int'(alu_iss_id[q*ID_W +: ID_W]), aid);
        expect_eq(req, $sformatf("q%0d agu_vld", q), int'(agu_iss_vld[q]), gv);
        if (gv != 0) expect_eq(req, $sformatf("q%0d agu_id", q), int'(agu_iss_id[q*ID_W +: ID_W]), gid);
        expect_eq(req, $sformatf("q%0d cmp0_vld", q), int'(cmp_vld[2*q]), c0v);
        if (c0v != 0) expect_eq(req, $sformatf("q%0d cmp0_id", q), int'(cmp_id[2*q*ID_W +: ID_W]), c0id);
        expect_eq(req, $sformatf("q%0d cmp1_vld", q), int'(cmp_vld[2*q+1]), c1v);
        if (c1v != 0) expect_eq(req, $sformatf("q%0d cmp1_id", q), int'(cmp_id[(2*q+1)*ID_W +: ID_W]), c1id);
    endtask

    task automatic expect_rdy(input string req, input int q, input int exp);
        expect_eq(req, $sformatf("q%0d dsp_rdy", q), int'(dsp_rdy[q]), exp);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        clear_inputs();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        for (int q = 0; q < NQ; q++) begin
            look("R8 reset", q, 0, 0, 0, 0, 0, 0, 0, 0);
            expect_rdy("R8 reset", q, 1);
        end
        tick();

        // R1 R2 R7 R8: fill each queue, drain arithmetic halves, then address halves
        for (int q = 0; q < NQ; q++) begin
            for (int k = 0; k < DEPTH; k++) begin
                put(q, 16 + k, 40, 40, 41, 41, 4'b0000);
                look("R1 fill", q, 0, 0, 0, 0, 0, 0, 0, 0);
                expect_rdy("R8 fill", q, 1);
                tick();
            end
            look("R1 full", q, 0, 0, 0, 0, 0, 0, 0, 0);
            expect_rdy("R8 full", q, 0);
            put(q, 63, 0, 0, 0, 0, 4'b1111);   // dropped: queue full
            tick();
            pulse(0, 40);
            look("R7 alu order", q, 1, 16, 0, 0, 0, 0, 0, 0);
            tick();
            for (int k = 1; k < DEPTH; k++) begin
                look("R7 alu order", q, 1, 16 + k, 0, 0, 0, 0, 0, 0);
                expect_rdy("R8 no completion", q, 0);
                tick();
            end
            look("R2 agu still waiting", q, 0, 0, 0, 0, 0, 0, 0, 0);
            tick();
            for (int k = 0; k < DEPTH; k++) begin
                if (k == 0) pulse(1, 41);
                look("R6 agu completes", q, 0, 0, 1, 16 + k, 0, 0, 1, 16 + k);
                if (k > 0) expect_rdy("R8 freed slot", q, 1);
                tick();
            end
            look("R8 dropped dispatch absent", q, 0, 0, 0, 0, 0, 0, 0, 0);
            expect_rdy("R8 empty", q, 1);
            tick();
        end

        // R7 R3: age order independent of slot position
        put(0, 1, 0, 0, 0, 0, 4'b1111);
        look("R3 not before t+1", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        tick();
        put(0, 2, 30, 30, 30, 30, 4'b0000);
        look("R6 both halves lane0", 0, 1, 1, 1, 1, 1, 1, 0, 0);
        tick();
        put(0, 3, 30, 30, 30, 30, 4'b0000);
        look("R3 waiting", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        tick();
        pulse(2, 30);
        look("R7 older in higher slot", 0, 1, 2, 1, 2, 1, 2, 0, 0);
        tick();
        look("R7 younger next", 0, 1, 3, 1, 3, 1, 3, 0, 0);
        tick();
        look("R7 drained", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        tick();

        // R9: broadcast in the dispatch cycle
        put(0, 4, 31, 31, 31, 31, 4'b0000);
        pulse(0, 31);
        look("R9 dispatch cycle", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        tick();
        look("R9 captured wakeup", 0, 1, 4, 1, 4, 1, 4, 0, 0);
        tick();

        // R4 R3: address half first, arithmetic half after a bus match
        put(0, 5, 0, 32, 0, 0, 4'b1101);
        tick();
        look("R4 agu first", 0, 0, 0, 1, 5, 0, 0, 0, 0);
        tick();
        look("R3 alu waits", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        tick();
        pulse(1, 32);
        look("R4 alu last completes", 0, 1, 5, 0, 0, 1, 5, 0, 0);
        tick();

        // R5 R6: halves of different macro-ops in one cycle
        put(0, 6, 0, 0, 33, 33, 4'b0011);
        tick();
        put(0, 7, 34, 34, 0, 0, 4'b1100);
        look("R4 alu of F", 0, 1, 6, 0, 0, 0, 0, 0, 0);
        tick();
        look("R4 agu of G", 0, 0, 0, 1, 7, 0, 0, 0, 0);
        tick();
        pulse(0, 33);
        pulse(1, 34);
        look("R5 mixed pair", 0, 1, 7, 1, 6, 1, 7, 1, 6);
        tick();
        look("R5 drained", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        tick();

        // R10: flush with pending ready entries and a dispatch in the flush cycle
        put(0, 8, 0, 0, 0, 0, 4'b1111);
        put(1, 9, 0, 0, 0, 0, 4'b1111);
        tick();
        flush = 1'b1;
        put(2, 10, 0, 0, 0, 0, 4'b1111);
        for (int q = 0; q < NQ; q++) begin
            look("R10 flush cycle", q, 0, 0, 0, 0, 0, 0, 0, 0);
            expect_rdy("R10 flush cycle", q, 0);
        end
        tick();
        for (int q = 0; q < NQ; q++) begin
            look("R10 after flush", q, 0, 0, 0, 0, 0, 0, 0, 0);
            expect_rdy("R10 after flush", q, 1);
        end
        tick();
        put(2, 11, 0, 0, 0, 0, 4'b1111);
        tick();
        look("R10 dispatch resumes", 2, 1, 11, 1, 11, 1, 11, 0, 0);
        tick();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule